// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that runs one MDIO frame at a time towards external PHY devices. A single serial engine produces both the clause 22 and the clause 45 frame formats; a mode bit picks which one is used. Software programs it through four 32-bit registers: a configuration register (clause select, preamble enable, MDC divider), a command register (operation, PHY address, register or device address), a write-data register and a read-data register. Progress is reported only through pending and valid flags inside the two data registers.

For a write, or for a clause 45 address cycle, software first loads the 16-bit payload into the write-data register and then writes the command; the command write launches the frame. For a read, the command write launches the frame and the result appears in the read-data register together with a valid flag. MDC is derived from the system clock by a programmable half-period divider. The block presents MDIO as a data output, an output enable and a data input for an external tri-state pad.

The engine is a state machine with five states: IDLE (MDC held low, waiting for a command), PREAMBLE (32 one bits, entered only when preamble is enabled), HEADER (14 bits: start, op, PHY address, register/device address), TURN (the 2 turnaround bits) and PAYLOAD (16 data bits). Transitions: IDLE to PREAMBLE or to HEADER on an accepted command, depending on the preamble bit; PREAMBLE to HEADER, HEADER to TURN, TURN to PAYLOAD and PAYLOAD to IDLE, each on the MDC falling edge that ends the last bit of the current state.

Top module: `mdio_master`

## Requirements
- R1: Register offsets are 0 configuration, 1 command, 2 write data, 3 read data. Configuration bit 0 selects clause 45 framing when 1; bit 1 enables the preamble; bits 15:8 hold the MDC half period in system clocks. A configuration write with bit 0 set also sets bit 1, and the register reads back as written otherwise. All registers read 0 after reset.
- R2: When the preamble bit is 1 a frame begins with 32 one bits on MDIO with the output enabled; when it is 0 the frame begins directly with the start bits.
- R3: In clause 22 mode a frame sends start 01, then op 01 for command op 0 (write) or 10 for command op 1 (read), then the 5-bit PHY address (command bits 12:8) and the 5-bit register address (command bits 20:16), MSB first; a write then sends turnaround 10 and the 16 write-data bits MSB first.
- R4: In clause 45 mode a frame sends start 00 followed by the command op field unchanged (0 address, 1 write, 2 read with post-increment, 3 read), then PHY address and device address as in R3; address and write frames send turnaround 10 and the write-data register contents.
- R5: An accepted command sets, on the clock edge of the command write, bit 31 of the write-data register for write and address operations or bit 31 of the read-data register for read operations; the flag clears when the frame has ended, and the two flags are never set together.
- R6: During a read the output enable is low for the turnaround and data bits; the 16 data bits are sampled on MDC rising edges and placed in read-data bits 15:0, and read-data bit 30 (valid) is set when the PHY drove 0 in the second turnaround bit.
- R7: If the PHY leaves the second turnaround bit at 1, the read completes with valid cleared; valid also stays 0 while a read is pending.
- R8: MDC is low while idle, each MDC phase lasts the configured half period (0 is treated as 1), and MDIO and its output enable change only together with an MDC falling edge once a frame has started.
- R9: A command write while a frame is in progress is ignored: no second frame follows.
- R10: In clause 22 mode a command with op 2 or 3 is ignored: no flag is set and MDC stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The assertions assume that software never rewrites the configuration register while a frame is running, so the divider and mode stay constant within one frame, and that the MDIO input is a defined level at every MDC rising edge. The stimulus keeps to this by writing configuration and write data only after polling the pending flag to zero, and by a PHY model in the bench that drives the input after every MDC falling edge and leaves it at the pulled-up 1 whenever the PHY is not talking.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_TURN,
        S_PAYLOAD
    } mdio_state_e;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_CMD  = 2'd1;
    localparam logic [1:0] ADDR_WDAT = 2'd2;
    localparam logic [1:0] ADDR_RDAT = 2'd3;

    localparam int PRE_BITS  = 32;
    localparam int HEAD_BITS = 14;
    localparam int TURN_BITS = 2;
    localparam int DATA_BITS = 16;
    localparam int FRAME_BITS = HEAD_BITS + TURN_BITS + DATA_BITS;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (half == '0) ? '0 : half - DIV_W'(1);
    assign tick = run && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  pre_en,
    input  logic                  is_read,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  tick,
    input  logic                  mdio_i,
    output logic                  mdc,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_BITS-1:0]  rx_data,
    output logic                  ta_ok
);
    mdio_state_e state, state_nx;
    logic [4:0]            bit_cnt;
    logic [FRAME_BITS-1:0] tx_sr;
    logic                  rd_mode;
    logic                  rise, fall, last;

    assign rise = tick && !mdc;
    assign fall = tick && mdc;
    assign last = (bit_cnt == 5'd0);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = pre_en ? S_PREAMBLE : S_HEADER;
            S_PREAMBLE: if (fall && last) state_nx = S_HEADER;
            S_HEADER:   if (fall && last) state_nx = S_TURN;
            S_TURN:     if (fall && last) state_nx = S_PAYLOAD;
            S_PAYLOAD:  if (fall && last) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc     <= 1'b0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_data <= '0;
            rd_mode <= 1'b0;
            ta_ok   <= 1'b0;
        end else if (state == S_IDLE) begin
            mdc <= 1'b0;
            if (start) begin
                tx_sr   <= frame;
                rd_mode <= is_read;
                ta_ok   <= 1'b0;
                bit_cnt <= pre_en ? 5'(PRE_BITS - 1) : 5'(HEAD_BITS - 1);
            end
        end else if (tick) begin
            mdc <= !mdc;
            if (rise) begin
                if (state == S_TURN && last && rd_mode) ta_ok <= !mdio_i;
                if (state == S_PAYLOAD) rx_data <= {rx_data[DATA_BITS-2:0], mdio_i};
            end else begin
                if (state != S_PREAMBLE) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                if (last) begin
                    unique case (state)
                        S_PREAMBLE: bit_cnt <= 5'(HEAD_BITS - 1);
                        S_HEADER:   bit_cnt <= 5'(TURN_BITS - 1);
                        S_TURN:     bit_cnt <= 5'(DATA_BITS - 1);
                        default:    bit_cnt <= '0;
                    endcase
                end else begin
                    bit_cnt <= bit_cnt - 5'd1;
                end
            end
        end
    end

    always_comb begin
        busy    = (state != S_IDLE);
        done    = fall && last && (state == S_PAYLOAD);
        mdio_o  = (state == S_IDLE || state == S_PREAMBLE) ? 1'b1 : tx_sr[FRAME_BITS-1];
        mdio_oe = busy && !(rd_mode && (state == S_TURN || state == S_PAYLOAD));
    end

    // R8
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R8
    mdio_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
    // R8
    mdc_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != $past(mdc)) |-> $past(tick));
    // R5
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                  cfg_c45, cfg_pre;
    logic [DIV_W-1:0]      cfg_half;
    logic [DATA_BITS-1:0]  wdat, rdat;
    logic                  wr_pend, rd_pend, rd_valid;
    logic                  cmd_wr, legal, busy, start, is_read;
    logic [1:0]            op, op_code;
    logic [FRAME_BITS-1:0] frame;
    logic                  tick, eng_busy, eng_done, eng_ok;
    logic [DATA_BITS-1:0]  eng_rx;

    assign op      = reg_wdata[1:0];
    assign cmd_wr  = reg_we && (reg_addr == ADDR_CMD);
    assign legal   = cfg_c45 || !op[1];
    assign busy    = wr_pend || rd_pend;
    assign start   = cmd_wr && legal && !busy;
    assign is_read = cfg_c45 ? op[1] : op[0];
    assign op_code = cfg_c45 ? op : {op[0], ~op[0]};
    assign frame   = {(cfg_c45 ? 2'b00 : 2'b01), op_code, reg_wdata[12:8],
                      reg_wdata[20:16], 2'b10, wdat};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_c45  <= 1'b0;
            cfg_pre  <= 1'b0;
            cfg_half <= '0;
            wdat     <= '0;
            rdat     <= '0;
            wr_pend  <= 1'b0;
            rd_pend  <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            if (reg_we && reg_addr == ADDR_CFG) begin
                cfg_c45  <= reg_wdata[0];
                cfg_pre  <= reg_wdata[1] | reg_wdata[0];
                cfg_half <= reg_wdata[8 +: DIV_W];
            end
            if (reg_we && reg_addr == ADDR_WDAT) wdat <= reg_wdata[DATA_BITS-1:0];
            if (start) begin
                wr_pend  <= !is_read;
                rd_pend  <= is_read;
                if (is_read) rd_valid <= 1'b0;
            end else if (eng_done) begin
                wr_pend <= 1'b0;
                rd_pend <= 1'b0;
                if (rd_pend) begin
                    rdat     <= eng_rx;
                    rd_valid <= eng_ok;
                end
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CFG:  reg_rdata = 32'({cfg_half, 6'b0, cfg_pre, cfg_c45});
            ADDR_WDAT: reg_rdata = {wr_pend, 15'b0, wdat};
            ADDR_RDAT: reg_rdata = {rd_pend, rd_valid, 14'b0, rdat};
            default:   reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .half (cfg_half),
        .tick (tick)
    );

    mdio_engine u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .pre_en (cfg_pre),
        .is_read(is_read),
        .frame  (frame),
        .tick   (tick),
        .mdio_i (mdio_i),
        .mdc    (mdc),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .busy   (eng_busy),
        .done   (eng_done),
        .rx_data(eng_rx),
        .ta_ok  (eng_ok)
    );

    // R1
    pre_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_c45 |-> cfg_pre);
    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pend && rd_pend));
    // R7
    valid_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |-> !rd_valid);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !eng_busy);
    // R10
    c22_bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cfg_c45 && op[1] && !busy) |=> !(wr_pend || rd_pend));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    typedef struct {
        logic [63:0] b;
        logic [63:0] oe;
        int          len;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    exp_t        sb_q[$];
    logic [63:0] reply = '1;
    int          phy_idx = 0;
    int          mon_idx = 0;
    logic [63:0] act_b = '0, act_oe = '0;
    int          rise_cnt = 0;
    realtime     t_prev = 0, t_last = 0;

    always #10 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic exp_t build(bit c45, bit pre, logic [1:0] op, logic [4:0] phy,
                                   logic [4:0] rg, logic [15:0] wd, string req);
        exp_t e;
        int p = pre ? 32 : 0;
        bit rdm = c45 ? op[1] : op[0];
        logic [31:0] f;
        f = {(c45 ? 2'b00 : 2'b01), (c45 ? op : {op[0], ~op[0]}), phy, rg, 2'b10, wd};
        e.b = '0; e.oe = '0; e.len = p + 32; e.req = req;
        for (int i = 0; i < p; i++) begin e.b[i] = 1'b1; e.oe[i] = 1'b1; end
        for (int j = 0; j < 32; j++) begin
            e.b[p+j]  = f[31-j];
            e.oe[p+j] = !(rdm && j >= 14);
        end
        return e;
    endfunction

    // PHY model: drives bit k after the k-th MDC falling edge
    initial forever begin
        @(negedge mdc);
        #1;
        phy_idx++;
        mdio_i = (phy_idx < 64) ? reply[phy_idx] : 1'b1;
    end

    // Monitor: collects each frame at MDC rising edges and compares with the scoreboard
    initial forever begin
        @(posedge mdc);
        #1;
        rise_cnt++;
        t_prev = t_last;
        t_last = $realtime;
        if (sb_q.size() == 0) begin
            check(1'b0, "R9", "MDC pulse with no frame expected", 64'(rise_cnt), 64'd0);
        end else begin
            act_b[mon_idx]  = mdio_o;
            act_oe[mon_idx] = mdio_oe;
            mon_idx++;
            if (mon_idx == sb_q[0].len) begin
                check(act_oe == sb_q[0].oe, sb_q[0].req, "frame output-enable pattern",
                      act_oe, sb_q[0].oe);
                check((act_b & sb_q[0].oe) == (sb_q[0].b & sb_q[0].oe), sb_q[0].req,
                      "frame bit pattern", act_b & sb_q[0].oe, sb_q[0].b & sb_q[0].oe);
                void'(sb_q.pop_front());
                mon_idx = 0; act_b = '0; act_oe = '0;
            end
        end
    end

    task automatic wait_idle(logic [1:0] a, string req);
        logic [31:0] d;
        int n = 0;
        do begin reg_read(a, d); n++; end while (d[31] && n < 3000);
        check(!d[31], req, "pending flag clears at frame end", 64'(d[31]), 64'd0);
        check(sb_q.size() == 0, req, "frame fully sent when pending clears",
              64'(sb_q.size()), 64'd0);
    endtask

    task automatic txn(string req, bit c45, bit pre, logic [7:0] half, logic [1:0] op,
                       logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                       logic [15:0] rd_val, bit ta_good);
        logic [31:0] d;
        int p = (pre || c45) ? 32 : 0;
        bit rdm = c45 ? op[1] : op[0];
        logic [1:0] flag_reg = rdm ? 2'd3 : 2'd2;
        reg_write(2'd0, {16'b0, half, 6'b0, pre, c45});
        reg_write(2'd2, {16'b0, wd});
        sb_q.push_back(build(c45, pre || c45, op, phy, rg, wd, req));
        reply = '1;
        if (rdm) begin
            reply[p+15] = !ta_good;
            for (int k = 0; k < 16; k++) reply[p+16+k] = rd_val[15-k];
        end
        phy_idx = 0;
        mdio_i = reply[0];
        reg_write(2'd1, {11'b0, rg, 3'b0, phy, 6'b0, op});
        reg_read(flag_reg, d);
        check(d[31], "R5", "pending flag set after command", 64'(d[31]), 64'd1);
        wait_idle(flag_reg, "R5");
        if (rdm) begin
            reg_read(2'd3, d);
            check(d[30] == ta_good, ta_good ? "R6" : "R7", "read valid flag",
                  64'(d[30]), 64'(ta_good));
            if (ta_good)
                check(d[15:0] == rd_val, "R6", "read data", 64'(d[15:0]), 64'(rd_val));
        end
    endtask

    initial begin
        logic [31:0] d;
        int rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), d);
            check(d == 32'd0, "R1", "register reads 0 after reset", 64'(d), 64'd0);
        end
        check(mdc == 1'b0, "R8", "MDC low after reset", 64'(mdc), 64'd0);

        // R1: clause 45 select forces preamble on
        reg_write(2'd0, 32'h0000_0201);
        reg_read(2'd0, d);
        check(d[15:0] == 16'h0203, "R1", "c45 config readback", 64'(d[15:0]), 64'h0203);
        reg_write(2'd0, 32'h0000_0500);
        reg_read(2'd0, d);
        check(d[15:0] == 16'h0500, "R1", "c22 config readback", 64'(d[15:0]), 64'h0500);

        // R3 / R2: clause 22 write without preamble
        txn("R3", 1'b0, 1'b0, 8'd2, 2'd0, 5'h05, 5'h03, 16'hA5C3, 16'h0, 1'b1);
        // R2 / R6: clause 22 read with preamble
        txn("R2", 1'b0, 1'b1, 8'd2, 2'd1, 5'h1F, 5'h11, 16'h0000, 16'h1234, 1'b1);
        // R4: clause 45 address, write, read-inc, read
        txn("R4", 1'b1, 1'b0, 8'd1, 2'd0, 5'h02, 5'h01, 16'h8001, 16'h0, 1'b1);
        txn("R4", 1'b1, 1'b0, 8'd2, 2'd1, 5'h02, 5'h03, 16'h7E55, 16'h0, 1'b1);
        txn("R4", 1'b1, 1'b0, 8'd2, 2'd2, 5'h0A, 5'h1E, 16'h0000, 16'hBEEF, 1'b1);
        txn("R6", 1'b1, 1'b0, 8'd2, 2'd3, 5'h13, 5'h04, 16'h0000, 16'h00FF, 1'b1);
        // R7: PHY absent, turnaround bit stays 1
        txn("R7", 1'b0, 1'b0, 8'd2, 2'd1, 5'h07, 5'h02, 16'h0000, 16'hFFFF, 1'b0);

        // R8: divider 3 gives a 6-clock MDC period; half 0 acts as 1
        txn("R8", 1'b0, 1'b0, 8'd3, 2'd0, 5'h01, 5'h01, 16'h0F0F, 16'h0, 1'b1);
        check((t_last - t_prev) == 120.0, "R8", "MDC period for half period 3",
              64'(int'(t_last - t_prev)), 64'd120);
        txn("R8", 1'b0, 1'b0, 8'd0, 2'd0, 5'h01, 5'h01, 16'h1111, 16'h0, 1'b1);
        check((t_last - t_prev) == 40.0, "R8", "MDC period for half period 0",
              64'(int'(t_last - t_prev)), 64'd40);

        // R9: second command while busy is ignored
        reg_write(2'd0, 32'h0000_0200);
        reg_write(2'd2, 32'h0000_C0DE);
        sb_q.push_back(build(1'b0, 1'b0, 2'd0, 5'h09, 5'h08, 16'hC0DE, "R9"));
        reply = '1; phy_idx = 0; mdio_i = 1'b1;
        reg_write(2'd1, {11'b0, 5'h08, 3'b0, 5'h09, 6'b0, 2'd0});
        reg_write(2'd1, {11'b0, 5'h1C, 3'b0, 5'h15, 6'b0, 2'd1});
        wait_idle(2'd2, "R9");
        rc = rise_cnt;
        repeat (300) @(negedge clk);
        check(rise_cnt == rc, "R9", "no second frame after ignored command",
              64'(rise_cnt), 64'(rc));
        reg_read(2'd3, d);
        check(!d[31], "R9", "no read pending from ignored command", 64'(d[31]), 64'd0);

        // R10: clause 22 op 2 and 3 ignored
        for (int o = 2; o < 4; o++) begin
            rc = rise_cnt;
            reg_write(2'd1, {11'b0, 5'h01, 3'b0, 5'h01, 6'b0, 2'(o)});
            reg_read(2'd2, d);
            check(!d[31], "R10", "no write pending for illegal op", 64'(d[31]), 64'd0);
            reg_read(2'd3, d);
            check(!d[31], "R10", "no read pending for illegal op", 64'(d[31]), 64'd0);
            repeat (100) @(negedge clk);
            check(rise_cnt == rc && mdc == 1'b0, "R10", "MDC idle after illegal op",
                  64'(rise_cnt), 64'(rc));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R5", "watchdog expired", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule